// File: doc/BRIEF.md
# Dual Timer/Counter Unit

This block provides two 16-bit timer/counter channels for an 8-bit microcontroller subsystem. Each channel keeps its count in a low byte and a high byte. A channel advances once per clock as a timer, or once per falling edge of its event pin as a counter. An external gate pin can hold a channel off until the pin goes high. A shared mode byte gives each channel one of four layouts:

- a 13-bit count with a 5-bit prescaler,
- a full 16-bit count,
- an 8-bit count that reloads itself from the high byte,
- a split layout, in which channel 0 becomes two independent 8-bit counters and channel 1 stops.

A control byte holds the two run bits and the two overflow flags. Software reaches both bytes and all four count bytes through a small synchronous register port. Reads from that port are combinational and show the live count.

Top module: `duo_tmr`

## Requirements
- R1: After a synchronous active-low reset, every register reads 0 and both flag outputs are 0.
- R2: The mode byte (address 0) reads back what was written. Its fields are: bit 7 gate for channel 1, bit 6 counter select for channel 1, bits 5:4 mode for channel 1, bit 3 gate for channel 0, bit 2 counter select for channel 0, bits 1:0 mode for channel 0. The control byte (address 1) holds flag 1 in bit 7, run 1 in bit 6, flag 0 in bit 5 and run 0 in bit 4. Its bits 3:0 read 0.
- R3: A channel steps only while its run bit is 1. If its gate bit is also 1, it steps only while its gate pin is also high.
- R4: With the counter select bit at 0, an enabled channel steps on every clock. With it at 1, the channel steps once for each event pin sample that is high in one cycle and low in the next. A pin held at one level causes no steps.
- R5: Mode 00 counts 13 bits. Low bits 4:0 act as a prescaler, and the high byte advances when they wrap. Low bits 7:5 hold their value. The step from 0x1FFF to 0 is an overflow.
- R6: Mode 01 counts {high, low} as 16 bits. The step from 0xFFFF to 0 is an overflow.
- R7: Mode 10 counts the low byte. On a step from 0xFF, the low byte takes the high byte's value, which is an overflow. The high byte does not change.
- R8: In mode 11, channel 1's count bytes do not change.
- R9: With channel 0 in mode 11, the following apply:
  - Channel 0's low byte counts as an 8-bit counter under channel 0's gate, counter select and run controls, and its wrap sets flag 0.
  - Channel 0's high byte counts every clock while run 1 is set, and its wrap sets flag 1.
  - Channel 1's own overflow does not set flag 1.
- R10: An overflow sets its flag, which stays set until a control write clears it. ovf_flag[0] shows flag 0 and ovf_flag[1] shows flag 1.
- R11: A bus write to a count byte takes effect over a step in the same cycle. The written byte takes the written value, and the channel's other byte keeps its value for that cycle.
- R12: Addresses 2, 3, 4 and 5 read channel 0 low, channel 0 high, channel 1 low and channel 1 high. These reads show the live count. Addresses 6 and 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for bus_addr |
| ev_pin | input | 2 | Event inputs for counter mode, one per channel |
| gate_pin | input | 2 | Gate inputs, one per channel |
| ovf_flag | output | 2 | Overflow flags of channels 1 and 0 |

## Verification
Some behaviour is checked by assertions on every clock:
- each single step of the 16-bit and reload layouts,
- the stillness of channel 1 while it is halted,
- the frozen upper low bits in the prescaled layout,
- a gate pin that blocks stepping,
- the precedence of a bus write over a step,
- flags that stay set until they are written.

Other behaviour only the bench's scenarios can show:
- the long-run arithmetic of each layout, including the wraps at 13 and 16 bits and the repeated reloads,
- the falling-edge counts under different pin waveforms,
- the routing of flags in the split layout, including the suppression of channel 1's own overflow,
- the full sweep of mode byte values.

// File: rtl/duo_tmr_pkg.sv
// Shared constants and types for the dual timer/counter unit.
package duo_tmr_pkg;
    localparam int BYTE_W = 8;

    // Per-channel operating layout, as encoded in the mode byte.
    typedef enum logic [1:0] {
        TM_PSC13   = 2'b00,
        TM_CAS16   = 2'b01,
        TM_RELOAD8 = 2'b10,
        TM_SPLIT   = 2'b11
    } tmr_mode_e;

    localparam logic [2:0] A_MODE = 3'd0;
    localparam logic [2:0] A_CTRL = 3'd1;
    localparam logic [2:0] A_LO0  = 3'd2;
    localparam logic [2:0] A_HI0  = 3'd3;
    localparam logic [2:0] A_LO1  = 3'd4;
    localparam logic [2:0] A_HI1  = 3'd5;
endpackage

// File: rtl/tmr_fall_det.sv
// Falling-edge detector for one event pin.
// Function: registers the pin once per clock and flags the cycle in which
//   the registered sample is high and the current pin is low.
// Assumes: the pin is synchronous to clk and stays at each level for at
//   least one full cycle.
module tmr_fall_det (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic tick_o
);
    logic last_q;

    // Keep the previous cycle's pin sample.
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= pin_i;
    end

    assign tick_o = last_q & ~pin_i;

    // R4
    tick_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !last_q);
endmodule

// File: rtl/tmr_chan.sv
// One timer/counter channel: a low byte, a high byte and the four layouts.
// Function: on step_i the count moves according to mode_i and ovf_o pulses
//   on a wrap. With SPLIT=1, mode 11 runs the low byte on step_i and the high
//   byte on alt_step_i, and a high-byte wrap pulses ovf_hi_o. With SPLIT=0,
//   mode 11 freezes the count.
// Assumes: a write to either byte preempts the whole channel's step that cycle.
module tmr_chan
    import duo_tmr_pkg::*;
#(
    parameter bit SPLIT = 1'b0,
    parameter int PSC_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  tmr_mode_e         mode_i,
    input  logic              step_i,
    input  logic              alt_step_i,
    input  logic              wr_lo_i,
    input  logic              wr_hi_i,
    input  logic [BYTE_W-1:0] wdata_i,
    output logic [BYTE_W-1:0] lo_o,
    output logic [BYTE_W-1:0] hi_o,
    output logic              ovf_o,
    output logic              ovf_hi_o
);
    localparam int               CW      = 2 * BYTE_W;
    localparam logic [PSC_W-1:0] PSC_TOP = '1;
    localparam logic [BYTE_W-1:0] B_TOP  = '1;

    logic [BYTE_W-1:0] lo_q, hi_q, lo_n, hi_n;
    logic              wr_any;

    assign wr_any = wr_lo_i | wr_hi_i;

    // Next-count selection per layout, with bus writes taking precedence.
    always_comb begin
        lo_n     = lo_q;
        hi_n     = hi_q;
        ovf_o    = 1'b0;
        ovf_hi_o = 1'b0;
        if (wr_any) begin
            if (wr_lo_i) lo_n = wdata_i;
            if (wr_hi_i) hi_n = wdata_i;
        end else begin
            case (mode_i)
                TM_PSC13: if (step_i) begin
                    if (lo_q[PSC_W-1:0] == PSC_TOP) begin
                        lo_n[PSC_W-1:0] = '0;
                        hi_n            = hi_q + 1'b1;
                        ovf_o           = (hi_q == B_TOP);
                    end else begin
                        lo_n[PSC_W-1:0] = lo_q[PSC_W-1:0] + 1'b1;
                    end
                end
                TM_CAS16: if (step_i) begin
                    {hi_n, lo_n} = {hi_q, lo_q} + CW'(1);
                    ovf_o        = &{hi_q, lo_q};
                end
                TM_RELOAD8: if (step_i) begin
                    if (lo_q == B_TOP) begin
                        lo_n  = hi_q;
                        ovf_o = 1'b1;
                    end else begin
                        lo_n = lo_q + 1'b1;
                    end
                end
                default: if (SPLIT) begin
                    if (step_i) begin
                        lo_n  = lo_q + 1'b1;
                        ovf_o = (lo_q == B_TOP);
                    end
                    if (alt_step_i) begin
                        hi_n     = hi_q + 1'b1;
                        ovf_hi_o = (hi_q == B_TOP);
                    end
                end
            endcase
        end
    end

    // Count byte storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            lo_q <= lo_n;
            hi_q <= hi_n;
        end
    end

    assign lo_o = lo_q;
    assign hi_o = hi_q;

    // R6
    cas16_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == TM_CAS16 && step_i && !wr_any)
        |=> ({hi_q, lo_q} == CW'($past({hi_q, lo_q}) + CW'(1))));

    // R7
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == TM_RELOAD8 && step_i && lo_q == B_TOP && !wr_any)
        |=> (lo_q == $past(hi_q) && $stable(hi_q)));

    // R5
    psc_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == TM_PSC13 && !wr_any) |=> $stable(lo_q[BYTE_W-1:PSC_W]));

    // R8
    halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!SPLIT && mode_i == TM_SPLIT && !wr_any) |=> $stable({hi_q, lo_q}));

    // R11
    wr_pri_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lo_i && !wr_hi_i) |=> (lo_q == $past(wdata_i) && $stable(hi_q)));
endmodule

// File: rtl/tmr_regs.sv
// Mode and control registers of the dual timer/counter unit.
// Function: stores the mode byte, the two run bits and the two overflow
//   flags. Overflow pulses set flags, and a control write overrides them.
// Assumes: set_f_i pulses are single-cycle and come from the channels.
module tmr_regs
    import duo_tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_mode_i,
    input  logic              wr_ctrl_i,
    input  logic [BYTE_W-1:0] wdata_i,
    input  logic [1:0]        set_f_i,
    output logic [BYTE_W-1:0] mode_o,
    output logic [1:0]        run_o,
    output logic [1:0]        flag_o
);
    logic [BYTE_W-1:0] mode_q;
    logic [1:0]        run_q, flag_q;

    // Register updates: bus writes first, then flag setting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            run_q  <= '0;
            flag_q <= '0;
        end else begin
            if (wr_mode_i) mode_q <= wdata_i;
            if (wr_ctrl_i) begin
                run_q  <= {wdata_i[6], wdata_i[4]};
                flag_q <= {wdata_i[7], wdata_i[5]};
            end else begin
                flag_q <= flag_q | set_f_i;
            end
        end
    end

    assign mode_o = mode_q;
    assign run_o  = run_q;
    assign flag_o = flag_q;

    // R10
    flag0_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q[0] && !wr_ctrl_i) |=> flag_q[0]);

    // R10
    flag1_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q[1] && !wr_ctrl_i) |=> flag_q[1]);

    // R10
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_f_i[0] && !wr_ctrl_i) |=> flag_q[0]);
endmodule

// File: rtl/duo_tmr.sv
// Dual timer/counter unit, top level.
// Function: decodes the register port, derives each channel's step from its
//   run, gate and counter-select fields, routes overflows to the flags, and
//   muxes the read data.
// Assumes: ev_pin and gate_pin are synchronous to clk.
module duo_tmr
    import duo_tmr_pkg::*;
#(
    parameter int PSC_W = 5
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic [2:0]  bus_addr,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata,
    input  logic [1:0]  ev_pin,
    input  logic [1:0]  gate_pin,
    output logic [1:0]  ovf_flag
);
    localparam int NCH = 2;

    logic [BYTE_W-1:0] mode_r;
    logic [1:0]        run_r, flag_r, set_f;
    logic [NCH-1:0]    tick_w, step_w, ovf_w, ovf_hi_w;
    logic [BYTE_W-1:0] lo_w [NCH];
    logic [BYTE_W-1:0] hi_w [NCH];
    tmr_mode_e         md_w [NCH];

    generate
        for (genvar g = 0; g < NCH; g++) begin : g_ch
            localparam logic [2:0] LO_A = 3'(2 + 2 * g);
            localparam logic [2:0] HI_A = 3'(3 + 2 * g);
            logic gate_b, ct_b, en_b;

            assign gate_b  = mode_r[4*g+3];
            assign ct_b    = mode_r[4*g+2];
            assign md_w[g] = tmr_mode_e'(mode_r[4*g+1 -: 2]);
            assign en_b    = run_r[g] & (~gate_b | gate_pin[g]);
            assign step_w[g] = en_b & (ct_b ? tick_w[g] : 1'b1);

            tmr_fall_det u_edge (
                .clk    (clk),
                .rst_n  (rst_n),
                .pin_i  (ev_pin[g]),
                .tick_o (tick_w[g])
            );

            tmr_chan #(.SPLIT(g == 0), .PSC_W(PSC_W)) u_chan (
                .clk        (clk),
                .rst_n      (rst_n),
                .mode_i     (md_w[g]),
                .step_i     (step_w[g]),
                .alt_step_i ((g == 0) ? run_r[1] : 1'b0),
                .wr_lo_i    (bus_wr && bus_addr == LO_A),
                .wr_hi_i    (bus_wr && bus_addr == HI_A),
                .wdata_i    (bus_wdata),
                .lo_o       (lo_w[g]),
                .hi_o       (hi_w[g]),
                .ovf_o      (ovf_w[g]),
                .ovf_hi_o   (ovf_hi_w[g])
            );
        end
    endgenerate

    // Flag routing: in split layout channel 1 loses its flag to channel 0's high byte.
    always_comb begin
        set_f[0] = ovf_w[0];
        set_f[1] = (ovf_w[1] & (md_w[0] != TM_SPLIT)) | (|ovf_hi_w);
    end

    tmr_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_mode_i (bus_wr && bus_addr == A_MODE),
        .wr_ctrl_i (bus_wr && bus_addr == A_CTRL),
        .wdata_i   (bus_wdata),
        .set_f_i   (set_f),
        .mode_o    (mode_r),
        .run_o     (run_r),
        .flag_o    (flag_r)
    );

    // Read data multiplexer over the live registers.
    always_comb begin
        case (bus_addr)
            A_MODE:  bus_rdata = mode_r;
            A_CTRL:  bus_rdata = {flag_r[1], run_r[1], flag_r[0], run_r[0], 4'b0000};
            A_LO0:   bus_rdata = lo_w[0];
            A_HI0:   bus_rdata = hi_w[0];
            A_LO1:   bus_rdata = lo_w[1];
            A_HI1:   bus_rdata = hi_w[1];
            default: bus_rdata = '0;
        endcase
    end

    assign ovf_flag = flag_r;

    // R3
    gate_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (md_w[0] != TM_SPLIT && mode_r[3] && !gate_pin[0]
         && !(bus_wr && (bus_addr == A_LO0 || bus_addr == A_HI0)))
        |=> $stable({hi_w[0], lo_w[0]}));
endmodule

// File: tb/duo_tmr_tb.sv
module duo_tmr_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [1:0] ev_pin = '0;
    logic [1:0] gate_pin = '0;
    logic [1:0] ovf_flag;

    int total = 0;
    int bad = 0;
    logic [7:0] rv, rl, rh;

    always #5 clk = ~clk;

    duo_tmr u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ev_pin(ev_pin),
        .gate_pin(gate_pin), .ovf_flag(ovf_flag)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic rd16(input int ch, output int v);
        logic [7:0] l, h;
        rd(3'(2 + 2 * ch), l);
        rd(3'(3 + 2 * ch), h);
        v = {h, l};
    endtask

    task automatic done();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        done();
    end

    initial begin
        int v, e, lo_e, hi_e, t, k0, base1, baseh, prevp, newp, gcur;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 and R12: every address reads 0 after reset
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), rv);
            chk("R1/R12 reset read", rv, 0);
        end
        chk("R1 flags", ovf_flag, 0);

        // R2: control byte readback, low nibble reads 0
        wr(3'd1, 8'hFF); rd(3'd1, rv); chk("R2 ctrl readback", rv, 8'hF0);
        chk("R10 flags written", ovf_flag, 3);
        wr(3'd1, 8'h00); rd(3'd1, rv); chk("R10 flags cleared", rv, 0);
        chk("R10 flag out clear", ovf_flag, 0);
        // R2: mode byte full sweep
        for (int m = 0; m < 256; m++) begin
            wr(3'd0, 8'(m)); rd(3'd0, rv);
            chk("R2 mode readback", rv, m);
        end

        // R6 R10: 16-bit timer wraps and sets flag 0
        wr(3'd0, 8'h01); wr(3'd2, 8'hF0); wr(3'd3, 8'hFF); wr(3'd1, 8'h10);
        for (int k = 1; k <= 24; k++) begin
            @(negedge clk); rd16(0, v);
            chk("R6 cas16 count", v, (16'hFFF0 + k) & 16'hFFFF);
            chk("R10 flag0 after wrap", ovf_flag[0], (k >= 16) ? 1 : 0);
        end

        // R5: prescaled 13-bit layout, upper low bits held
        wr(3'd1, 8'h00); wr(3'd0, 8'h00); wr(3'd2, 8'hE0); wr(3'd3, 8'hFE);
        wr(3'd1, 8'h10);
        for (int k = 1; k <= 80; k++) begin
            @(negedge clk);
            t = (8128 + k) % 8192;
            rd(3'd2, rl); rd(3'd3, rh);
            chk("R5 psc low", rl, 8'hE0 | (t & 31));
            chk("R5 psc high", rh, t >> 5);
            chk("R5 wrap flag", ovf_flag[0], (k >= 64) ? 1 : 0);
        end

        // R7: auto-reload from high byte
        wr(3'd1, 8'h00); wr(3'd0, 8'h02); wr(3'd2, 8'hFD); wr(3'd3, 8'hFC);
        wr(3'd1, 8'h10);
        e = 8'hFD;
        for (int k = 1; k <= 20; k++) begin
            e = (e == 8'hFF) ? 8'hFC : e + 1;
            @(negedge clk);
            rd(3'd2, rl); rd(3'd3, rh);
            chk("R7 reload low", rl, e);
            chk("R7 high kept", rh, 8'hFC);
        end
        chk("R7 reload flag", ovf_flag[0], 1);

        // R4: counter mode on channel 1, ungated then gated (R3)
        wr(3'd1, 8'h00); wr(3'd0, 8'h50); wr(3'd4, 8'h00); wr(3'd5, 8'h00);
        wr(3'd1, 8'h40);
        e = 0; prevp = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk); rd16(1, v);
            chk("R4 event count", v, e);
            newp = (i < 20) ? ((i % 2 == 0) ? 1 : 0) : ((i % 5 < 2) ? 1 : 0);
            if (prevp == 1 && newp == 0) e++;
            ev_pin[1] = 1'(newp); prevp = newp;
        end
        @(negedge clk); rd16(1, v); chk("R4 event count end", v, e);
        wr(3'd0, 8'hD0);
        rd16(1, v); e = v;
        for (int i = 0; i < 48; i++) begin
            @(negedge clk); rd16(1, v);
            chk("R3 gated event count", v, e);
            newp = (i % 3 == 0) ? 1 : 0;
            gcur = (i / 8) % 2;
            if (prevp == 1 && newp == 0 && gcur == 1) e++;
            ev_pin[1] = 1'(newp); gate_pin[1] = 1'(gcur); prevp = newp;
        end
        @(negedge clk); rd16(1, v); chk("R3 gated count end", v, e);
        ev_pin[1] = 1'b0; gate_pin[1] = 1'b0;

        // R3: gated timer on channel 0
        wr(3'd1, 8'h00); wr(3'd0, 8'h09); wr(3'd2, 8'h00); wr(3'd3, 8'h00);
        wr(3'd1, 8'h10);
        for (int k = 1; k <= 8; k++) begin
            @(negedge clk); rd16(0, v); chk("R3 gate low holds", v, 0);
        end
        gate_pin[0] = 1'b1;
        for (int k = 1; k <= 8; k++) begin
            @(negedge clk); rd16(0, v); chk("R3 gate high runs", v, k);
        end
        gate_pin[0] = 1'b0;

        // R9: split layout with flag routing
        wr(3'd1, 8'h00); wr(3'd0, 8'h13);
        wr(3'd2, 8'hFA); wr(3'd3, 8'hF0); wr(3'd4, 8'hF8); wr(3'd5, 8'hFF);
        wr(3'd1, 8'h50);
        for (int k = 1; k <= 24; k++) begin
            @(negedge clk);
            rd(3'd2, rl); rd(3'd3, rh); rd16(1, v);
            lo_e = (8'hFA + k) & 8'hFF; hi_e = (8'hF0 + k) & 8'hFF;
            chk("R9 split low", rl, lo_e);
            chk("R9 split high", rh, hi_e);
            chk("R9 ch1 runs", v, (16'hFFF8 + k) & 16'hFFFF);
            chk("R9 flag0", ovf_flag[0], (k >= 6) ? 1 : 0);
            chk("R9 flag1 from split high", ovf_flag[1], (k >= 16) ? 1 : 0);
        end

        // R8: channel 1 halted while channel 0 high byte still runs
        wr(3'd0, 8'h33);
        rd16(1, base1); rd(3'd3, rh); baseh = rh;
        for (int k = 1; k <= 10; k++) begin
            @(negedge clk);
            rd16(1, v); rd(3'd3, rh);
            chk("R8 ch1 halted", v, base1);
            chk("R9 split high runs", rh, (baseh + k) & 8'hFF);
        end

        // R11: bus write wins over a same-cycle step
        wr(3'd1, 8'h00); wr(3'd0, 8'h01); wr(3'd2, 8'h30); wr(3'd3, 8'h12);
        wr(3'd1, 8'h10);
        repeat (3) @(negedge clk);
        wr(3'd2, 8'h55);
        rd(3'd2, rl); rd(3'd3, rh);
        chk("R11 written low", rl, 8'h55);
        chk("R11 high kept", rh, 8'h12);
        @(negedge clk); rd16(0, v);
        chk("R11 resumes", v, 16'h1256);
        k0 = 0;
        rd(3'd6, rv); chk("R12 addr6", rv, 0);
        rd(3'd7, rv); chk("R12 addr7", rv, k0);
        done();
    end
endmodule